// File: doc/BRIEF.md
# Flash Sector Erase Suspend Controller

This block is the command-side sequencer of a NOR-style flash. It watches decoded command writes, each one taken on the rising edge of an active-low write strobe, and tracks a sector erase through its phases. The phases are the timeout window in which more sectors may be added, the embedded erase, a pending suspend, the suspended state with an optional program to an unmarked sector, and resume. It also tracks chip erase and plain program operations, so that it knows when a suspend request has to be refused.

The array model reports the end of the current embedded operation on `op_done`. The controller reports its phase on `mode` and the set of sectors marked for erase on `erase_mask`. It raises `timer_expired` once the window has closed. Its `read_status` output tells the read path, for the sector on `rd_addr`, whether to return status instead of array data. Both timing figures are cycle-count parameters: the window length (50 µs at the core clock) and the suspend latency during active erase (up to 20 µs, typically 5 µs).

Top module: `flash_erase_susp_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it falls (which aborts any erase in progress), `mode` is 0 (array read), `erase_mask` is 0, `timer_expired` is 0 and `read_status` is 0.
- R2: A command is acted on only at the clock edge where `we_n` is first sampled high after being sampled low. The codes are 80h for sector erase (sector on `cmd_addr`), 10h for chip erase, A0h for program, B0h for suspend and 30h for resume. In array read, any code other than 80h, 10h or A0h is ignored.
- R3: Sector erase puts `mode` at 1 (window) with the addressed bit set in `erase_mask`. A further 80h inside the window ORs in its sector and restarts the window. `mode` becomes 2 (erasing) exactly WINDOW_CYC edges after the edge that took the last 80h.
- R4: `timer_expired` is 0 in array read and in the window. It is 1 from the end of the window, whether by timeout or by suspend, until the erase ends.
- R5: While erasing, every code except B0h is ignored: `mode` stays 2 and `erase_mask` is unchanged.
- R6: B0h in the window sets `mode` to 4 (suspended) on the edge that takes it.
- R7: B0h while erasing sets `mode` to 3 (suspend pending). `mode` becomes 4 exactly SUSP_LAT_CYC edges after the edge that took the command.
- R8: B0h is ignored during chip erase (`mode` 6) and during program (`mode` 7). Either one returns to 0 on `op_done`.
- R9: `read_status` is 0 in array read. In modes 4 and 5 it equals `erase_mask[rd_addr]`. In every other mode it is 1.
- R10: In mode 4, A0h to an unmarked sector enters mode 5 (suspended program), and `op_done` then returns the controller to mode 4. A0h to a marked sector is ignored.
- R11: In mode 4, 30h whose `cmd_addr` is marked in `erase_mask` returns to mode 2, and 30h to an unmarked sector is ignored. Once erase has restarted, further 30h writes are ignored and B0h is accepted again.
- R12: `op_done` in mode 2 or 3 returns the controller to mode 0 and clears `erase_mask` and `timer_expired`. It takes priority over a command on the same edge.
- R13: When the window expires on the same edge as a command write, the expiry wins: `mode` becomes 2 and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| we_n | input | 1 | Command write strobe, active low; the command is taken on its rising edge |
| cmd_code | input | 8 | Decoded command code |
| cmd_addr | input | SECT_W | Sector addressed by the command |
| op_done | input | 1 | The current embedded operation has finished |
| rd_addr | input | SECT_W | Sector currently being read |
| mode | output | 3 | Controller phase (0 array read, 1 window, 2 erasing, 3 suspend pending, 4 suspended, 5 suspended program, 6 chip erase, 7 program) |
| erase_mask | output | NSECT | Sectors marked for erase |
| timer_expired | output | 1 | The erase window has closed |
| read_status | output | 1 | 1 selects status, 0 selects array data, for `rd_addr` |

## Verification
The assertions check on every cycle the relations that hold edge to edge. These are: suspend in the window is taken at once, and non-suspend commands leave the erase untouched. A pending suspend waits for its latency event, chip erase and program hold through suspend, and a mismatched resume is ignored. Completion always lands in array read, and the status selector follows the mask while suspended. The exact cycle counts of the window and the suspend latency can only be shown by the bench's scenarios. The same goes for restarting the window with an added sector, the priority of expiry and completion over a coincident command, the full read and program sweep over every pair of suspended sector and addressed sector, and the reset abort.

// File: rtl/fecs_pkg.sv
package fecs_pkg;

  typedef enum logic [2:0] {
    M_IDLE      = 3'd0,
    M_WINDOW    = 3'd1,
    M_ERASING   = 3'd2,
    M_SUSP_PEND = 3'd3,
    M_SUSPENDED = 3'd4,
    M_SUSP_PROG = 3'd5,
    M_CHIP      = 3'd6,
    M_PROG      = 3'd7
  } mode_e;

  localparam logic [7:0] CMD_SECT_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP_ERASE = 8'h10;
  localparam logic [7:0] CMD_PROGRAM    = 8'hA0;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_RESUME     = 8'h30;

  // Read-path selector: status (1) or array data (0).
  function automatic logic status_select(input mode_e m, input logic marked);
    case (m)
      M_IDLE:                   return 1'b0;
      M_SUSPENDED, M_SUSP_PROG: return marked;
      default:                  return 1'b1;
    endcase
  endfunction

  // Counter width needed to count 0 .. limit-1.
  function automatic int count_width(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/fecs_strobe_edge.sv
module fecs_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b1;
    else        strobe_q <= strobe_n;
  end

  assign rise = strobe_n & ~strobe_q;
endmodule

// File: rtl/fecs_cycle_timer.sv
module fecs_cycle_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic expire
);
  import fecs_pkg::*;
  localparam int CW = count_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (stop || expire) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fecs_sector_mask.sv
module fecs_sector_mask #(
  parameter int NSECT  = 8,
  parameter int SECT_W = $clog2(NSECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              add,
  input  logic              clear,
  input  logic [SECT_W-1:0] sect_in,
  input  logic [SECT_W-1:0] probe_cmd,
  input  logic [SECT_W-1:0] probe_rd,
  output logic [NSECT-1:0]  mask,
  output logic              hit_cmd,
  output logic              hit_rd
);
  for (genvar g = 0; g < NSECT; g++) begin : g_bit
    logic sel;
    assign sel = (sect_in == SECT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask[g] <= 1'b0;
      else if (clear) mask[g] <= 1'b0;
      else if (load)  mask[g] <= sel;
      else if (add)   mask[g] <= mask[g] | sel;
    end
  end

  assign hit_cmd = mask[probe_cmd];
  assign hit_rd  = mask[probe_rd];
endmodule

// File: rtl/flash_erase_susp_ctrl.sv
module flash_erase_susp_ctrl #(
  parameter int NSECT        = 8,
  parameter int WINDOW_CYC   = 2500,
  parameter int SUSP_LAT_CYC = 1000,
  parameter int SECT_W       = $clog2(NSECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_n,
  input  logic [7:0]        cmd_code,
  input  logic [SECT_W-1:0] cmd_addr,
  input  logic              op_done,
  input  logic [SECT_W-1:0] rd_addr,
  output logic [2:0]        mode,
  output logic [NSECT-1:0]  erase_mask,
  output logic              timer_expired,
  output logic              read_status
);
  import fecs_pkg::*;

  mode_e mode_q, mode_d;
  logic  ev_cmd, ev_win_exp, ev_lat_exp;
  logic  win_start, win_stop, lat_start, lat_stop;
  logic  m_load, m_add, m_clear, exp_set, exp_clr;
  logic  hit_cmd, hit_rd, exp_q;

  fecs_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .strobe_n(we_n), .rise(ev_cmd)
  );

  fecs_cycle_timer #(.LIMIT(WINDOW_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .start(win_start), .stop(win_stop), .expire(ev_win_exp)
  );

  fecs_cycle_timer #(.LIMIT(SUSP_LAT_CYC)) u_lat (
    .clk(clk), .rst_n(rst_n), .start(lat_start), .stop(lat_stop), .expire(ev_lat_exp)
  );

  fecs_sector_mask #(.NSECT(NSECT), .SECT_W(SECT_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .load(m_load), .add(m_add), .clear(m_clear),
    .sect_in(cmd_addr), .probe_cmd(cmd_addr), .probe_rd(rd_addr),
    .mask(erase_mask), .hit_cmd(hit_cmd), .hit_rd(hit_rd)
  );

  always_comb begin
    mode_d    = mode_q;
    win_start = 1'b0;
    win_stop  = 1'b0;
    lat_start = 1'b0;
    lat_stop  = 1'b0;
    m_load    = 1'b0;
    m_add     = 1'b0;
    m_clear   = 1'b0;
    exp_set   = 1'b0;
    exp_clr   = 1'b0;
    case (mode_q)
      M_IDLE: begin
        if (ev_cmd) begin
          if (cmd_code == CMD_SECT_ERASE) begin
            mode_d    = M_WINDOW;
            win_start = 1'b1;
            m_load    = 1'b1;
            exp_clr   = 1'b1;
          end else if (cmd_code == CMD_CHIP_ERASE) begin
            mode_d = M_CHIP;
          end else if (cmd_code == CMD_PROGRAM) begin
            mode_d = M_PROG;
          end
        end
      end
      M_WINDOW: begin
        if (ev_win_exp) begin
          mode_d  = M_ERASING;
          exp_set = 1'b1;
        end else if (ev_cmd && cmd_code == CMD_SECT_ERASE) begin
          m_add     = 1'b1;
          win_start = 1'b1;
        end else if (ev_cmd && cmd_code == CMD_SUSPEND) begin
          mode_d   = M_SUSPENDED;
          win_stop = 1'b1;
          exp_set  = 1'b1;
        end
      end
      M_ERASING: begin
        if (op_done) begin
          mode_d  = M_IDLE;
          m_clear = 1'b1;
          exp_clr = 1'b1;
        end else if (ev_cmd && cmd_code == CMD_SUSPEND) begin
          mode_d    = M_SUSP_PEND;
          lat_start = 1'b1;
        end
      end
      M_SUSP_PEND: begin
        if (op_done) begin
          mode_d   = M_IDLE;
          m_clear  = 1'b1;
          exp_clr  = 1'b1;
          lat_stop = 1'b1;
        end else if (ev_lat_exp) begin
          mode_d = M_SUSPENDED;
        end
      end
      M_SUSPENDED: begin
        if (ev_cmd && cmd_code == CMD_PROGRAM && !hit_cmd) begin
          mode_d = M_SUSP_PROG;
        end else if (ev_cmd && cmd_code == CMD_RESUME && hit_cmd) begin
          mode_d = M_ERASING;
        end
      end
      M_SUSP_PROG: begin
        if (op_done) mode_d = M_SUSPENDED;
      end
      default: begin
        if (op_done) mode_d = M_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;
      exp_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (exp_clr)      exp_q <= 1'b0;
      else if (exp_set) exp_q <= 1'b1;
    end
  end

  assign mode          = mode_q;
  assign timer_expired = exp_q;
  assign read_status   = status_select(mode_q, hit_rd);
endmodule

// File: rtl/fecs_checker.sv
module fecs_checker #(
  parameter int NSECT  = 8,
  parameter int SECT_W = $clog2(NSECT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic [NSECT-1:0]  erase_mask,
  input logic              timer_expired,
  input logic              read_status,
  input logic              ev_cmd,
  input logic              ev_win_exp,
  input logic              ev_lat_exp,
  input logic [7:0]        cmd_code,
  input logic [SECT_W-1:0] cmd_addr,
  input logic [SECT_W-1:0] rd_addr,
  input logic              op_done
);
  import fecs_pkg::*;

  assert_idle_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE) |-> (erase_mask == '0) && !timer_expired && !read_status);

  assert_window_timer_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WINDOW) |-> !timer_expired);

  assert_erase_ignores_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERASING && ev_cmd && cmd_code != CMD_SUSPEND && !op_done)
      |=> (mode == M_ERASING) && $stable(erase_mask));

  assert_window_suspend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WINDOW && ev_cmd && cmd_code == CMD_SUSPEND && !ev_win_exp)
      |=> (mode == M_SUSPENDED));

  assert_pending_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SUSP_PEND && !ev_lat_exp && !op_done) |=> (mode == M_SUSP_PEND));

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_CHIP || mode == M_PROG) && !op_done) |=> $stable(mode));

  assert_status_marked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SUSPENDED) |-> (read_status == erase_mask[rd_addr]));

  assert_bad_resume_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SUSPENDED && ev_cmd && cmd_code == CMD_RESUME && !erase_mask[cmd_addr])
      |=> (mode == M_SUSPENDED));

  assert_done_to_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_ERASING || mode == M_SUSP_PEND) && op_done) |=> (mode == M_IDLE));
endmodule

bind flash_erase_susp_ctrl fecs_checker #(.NSECT(NSECT), .SECT_W(SECT_W)) u_fecs_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .erase_mask(erase_mask),
  .timer_expired(timer_expired), .read_status(read_status), .ev_cmd(ev_cmd),
  .ev_win_exp(ev_win_exp), .ev_lat_exp(ev_lat_exp), .cmd_code(cmd_code),
  .cmd_addr(cmd_addr), .rd_addr(rd_addr), .op_done(op_done)
);

// File: tb/test_flash_erase_susp_ctrl.sv
module test_flash_erase_susp_ctrl;
  import fecs_pkg::*;

  localparam int NS  = 4;
  localparam int SW  = 2;
  localparam int WIN = 6;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n, we_n, op_done;
  logic [7:0]    cmd_code;
  logic [SW-1:0] cmd_addr, rd_addr;
  logic [2:0]    mode;
  logic [NS-1:0] erase_mask;
  logic          timer_expired, read_status;
  int vectors = 0;
  int miscompares = 0;

  flash_erase_susp_ctrl #(.NSECT(NS), .WINDOW_CYC(WIN), .SUSP_LAT_CYC(LAT)) i_flash_erase_susp_ctrl (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .op_done(op_done), .rd_addr(rd_addr), .mode(mode), .erase_mask(erase_mask),
    .timer_expired(timer_expired), .read_status(read_status)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Strobe low one cycle, then high; the command acts on the following edge.
  task automatic wr(input logic [7:0] code, input int addr, input bit done_too = 1'b0);
    cmd_code = code;
    cmd_addr = SW'(addr);
    we_n = 1'b0;
    tick();
    we_n = 1'b1;
    op_done = done_too;
    tick();
    op_done = 1'b0;
  endtask

  task automatic done_pulse();
    op_done = 1'b1;
    tick();
    op_done = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    miscompares++;
    vectors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int mexp;
    rst_n = 1'b0; we_n = 1'b1; op_done = 1'b0;
    cmd_code = 8'h00; cmd_addr = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode, M_IDLE);
    chk("R1 reset mask", erase_mask, 0);
    chk("R1 reset expired", timer_expired, 0);
    chk("R1 reset status", read_status, 0);
    rst_n = 1'b1;
    tick();

    // R2: unknown and out-of-place codes in array read
    wr(8'h55, 1);        chk("R2 unknown code", mode, M_IDLE);
    wr(CMD_RESUME, 0);   chk("R2 resume idle", mode, M_IDLE);
    wr(CMD_SUSPEND, 0);  chk("R2 suspend idle", mode, M_IDLE);

    // R2: strobe held low does nothing until it rises
    cmd_code = CMD_SECT_ERASE; cmd_addr = 2'd1; we_n = 1'b0;
    repeat (3) begin tick(); chk("R2 strobe low", mode, M_IDLE); end
    we_n = 1'b1;
    tick();
    chk("R3 window entry", mode, M_WINDOW);
    chk("R3 window mask", erase_mask, 1 << 1);
    for (int i = 1; i < WIN; i++) begin
      tick();
      chk("R3 window hold", mode, M_WINDOW);
      chk("R4 window timer low", timer_expired, 0);
    end
    tick();
    chk("R3 window expiry", mode, M_ERASING);
    chk("R4 expired after window", timer_expired, 1);

    // R5: erasing ignores everything but suspend
    wr(CMD_SECT_ERASE, 2); chk("R5 sect erase dropped", mode, M_ERASING);
    chk("R5 mask unchanged", erase_mask, 1 << 1);
    wr(CMD_CHIP_ERASE, 0); chk("R5 chip dropped", mode, M_ERASING);
    wr(CMD_RESUME, 1);     chk("R5 resume dropped", mode, M_ERASING);
    wr(CMD_PROGRAM, 3);    chk("R5 program dropped", mode, M_ERASING);
    chk("R9 status erasing", read_status, 1);

    // R7: suspend latency during active erase
    wr(CMD_SUSPEND, 0);
    chk("R7 pending", mode, M_SUSP_PEND);
    for (int i = 1; i < LAT; i++) begin
      tick();
      chk("R7 pending hold", mode, M_SUSP_PEND);
    end
    tick();
    chk("R7 suspended after latency", mode, M_SUSPENDED);

    // R11: resume address match, repeat, re-suspend
    wr(CMD_RESUME, 2);   chk("R11 wrong resume", mode, M_SUSPENDED);
    wr(CMD_RESUME, 1);   chk("R11 resume", mode, M_ERASING);
    wr(CMD_RESUME, 1);   chk("R11 repeat resume", mode, M_ERASING);
    wr(CMD_SUSPEND, 0);  chk("R11 re-suspend", mode, M_SUSP_PEND);
    done_pulse();
    chk("R12 done while pending", mode, M_IDLE);
    chk("R12 mask cleared", erase_mask, 0);
    chk("R12 expired cleared", timer_expired, 0);

    // Sweep: every suspended sector against every addressed sector
    for (int s = 0; s < NS; s++) begin
      int wrong;
      wr(CMD_SECT_ERASE, s);
      mexp = 1 << s;
      if (s == 1) begin
        wr(CMD_SECT_ERASE, 3);
        mexp = mexp | (1 << 3);
      end
      chk("R3 window sweep", mode, M_WINDOW);
      wr(CMD_SUSPEND, 0);
      chk("R6 immediate suspend", mode, M_SUSPENDED);
      chk("R4 expired on suspend", timer_expired, 1);
      chk("R3 sweep mask", erase_mask, mexp);
      for (int a = 0; a < NS; a++) begin
        rd_addr = SW'(a);
        #1;
        chk("R9 read select", read_status, (mexp >> a) & 1);
      end
      for (int a = 0; a < NS; a++) begin
        wr(CMD_PROGRAM, a);
        if ((mexp >> a) & 1) begin
          chk("R10 program marked dropped", mode, M_SUSPENDED);
        end else begin
          chk("R10 suspended program", mode, M_SUSP_PROG);
          done_pulse();
          chk("R10 back to suspended", mode, M_SUSPENDED);
        end
      end
      wrong = (s + 1) % NS;
      wr(CMD_RESUME, wrong); chk("R11 sweep wrong resume", mode, M_SUSPENDED);
      wr(CMD_RESUME, s);     chk("R11 sweep resume", mode, M_ERASING);
      done_pulse();
      chk("R12 sweep done", mode, M_IDLE);
    end
    rd_addr = '0;

    // R3: restart window with an added sector
    wr(CMD_SECT_ERASE, 0);
    repeat (3) tick();
    wr(CMD_SECT_ERASE, 2);
    for (int i = 1; i < WIN; i++) begin
      tick();
      chk("R3 restarted hold", mode, M_WINDOW);
    end
    tick();
    chk("R3 restarted expiry", mode, M_ERASING);
    chk("R3 combined mask", erase_mask, 5);
    wr(CMD_SUSPEND, 0, 1'b1);
    chk("R12 done beats suspend", mode, M_IDLE);

    // R13: window expiry coincides with a suspend write
    wr(CMD_SECT_ERASE, 1);
    repeat (WIN - 2) tick();
    wr(CMD_SUSPEND, 0);
    chk("R13 expiry beats command", mode, M_ERASING);
    done_pulse();
    chk("R12 done after expiry", mode, M_IDLE);

    // R8: suspend refused during chip erase and program
    wr(CMD_CHIP_ERASE, 0); chk("R8 chip erase", mode, M_CHIP);
    wr(CMD_SUSPEND, 0);    chk("R8 suspend ignored chip", mode, M_CHIP);
    chk("R9 status chip", read_status, 1);
    done_pulse();          chk("R8 chip done", mode, M_IDLE);
    wr(CMD_PROGRAM, 1);    chk("R8 program", mode, M_PROG);
    wr(CMD_SUSPEND, 0);    chk("R8 suspend ignored program", mode, M_PROG);
    done_pulse();          chk("R8 program done", mode, M_IDLE);

    // R1: reset aborts an erase
    wr(CMD_SECT_ERASE, 2);
    repeat (WIN + 1) tick();
    chk("R1 erasing before reset", mode, M_ERASING);
    rst_n = 1'b0;
    tick();
    chk("R1 abort mode", mode, M_IDLE);
    chk("R1 abort mask", erase_mask, 0);
    chk("R1 abort expired", timer_expired, 0);
    rst_n = 1'b1;
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule